// File: doc/BRIEF.md
# I2C Bus Activity State Monitor

This block watches the sampled clock and data lines of a two-wire serial bus. It reports when the bus is free and when it is occupied. It recognises start and stop conditions, but it reports one only after the lines have held the condition for a programmable number of clock cycles. A start or stop is never reported from a single-sample glitch. The monitor runs whenever any of its three enables (controller, target, multi-controller) is asserted.

Alongside the condition detector, a four-state tracker follows the bus. The four states are:
- free;
- busy with the clock line low;
- busy with the clock line high;
- busy after a stop.

A shared release countdown decides when an idle bus counts as free again. The same countdown also measures how long the clock line is held low. From it the block raises single-cycle timeout events: one for a clock line stuck low, and one for an idle bus while the local target is still engaged.

The state entered when the monitor is switched on depends on the mode. With multi-controller mode on, the bus is first assumed to be taken, and it is released only after a full quiet period. Otherwise the bus is assumed free at once.

Top module: `bus_state_watch`

## Requirements
- R1: The monitor is enabled when any of `ctl_en_i`, `tgt_en_i` or `mc_en_i` is 1. While all three are 0, `start_o` and `stop_o` stay 0 for any line activity, and the tracker is held in the free state.
- R2: A start candidate is a cycle in which SCL is 1 in both the previous and the current sample while SDA goes from 1 to 0. With SCL staying 1 and no stop candidate in between, `start_o` is 1 for exactly one cycle, and that cycle comes `hold_cycles_i + 1` cycles after the candidate.
- R3: A stop candidate is a cycle in which SCL is 1 in both samples while SDA goes from 0 to 1. Under the same conditions as R2, `stop_o` is 1 for exactly one cycle, `hold_cycles_i + 1` cycles after the candidate.
- R4: A pending start is dropped, and never reported, if SCL goes low before it qualifies or if a stop candidate arrives. The stop candidate then starts its own qualification window. `start_o` and `stop_o` are never 1 in the same cycle.
- R5: In the free state, a 0 on SCL or SDA moves the tracker to busy-low, and busy-low moves to busy-high when SCL is 1. In multi-controller mode, `bus_free_o` is 1 exactly while the tracker is free.
- R6: Every state change reloads the release countdown from `release_cycles_i`. In busy-high with the lines idle (SCL 1, SDA unchanged), the tracker becomes free after `release_cycles_i` cycles. A change on the lines moves it back to busy-low. A value of 0 never releases the bus.
- R7: A confirmed stop in busy-low or busy-high moves the tracker to busy-after-stop. `bus_busy_o` is 0 only in that state. From there, a 0 on either line returns the tracker to busy-low, and `release_cycles_i` cycles with both lines at 1 make it free.
- R8: On the cycle the monitor becomes enabled, the countdown is loaded. The tracker enters busy-high if `mc_en_i` is 1, and the free state otherwise.
- R9: With `mc_en_i` at 0, `bus_free_o` reads 1 at all times.
- R10: In busy-low with SCL held at 0, the countdown reaching 1 makes `active_to_o` 1 for a single cycle.
- R11: In busy-high with the lines idle and `idle_to_en_i` at 1, the countdown reaching 1 makes `inactive_to_o` 1 for that cycle, but only while `tgt_idle_i` is 0.
- R12: While `rst_ni` is 0, `start_o`, `stop_o`, `active_to_o` and `inactive_to_o` are 0, `bus_busy_o` is 1, and the tracker is free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ctl_en_i | input | 1 | Controller function enabled |
| tgt_en_i | input | 1 | Target function enabled |
| mc_en_i | input | 1 | Multi-controller mode enabled |
| hold_cycles_i | input | QUAL_W (14) | Qualification window for start and stop, in cycles |
| release_cycles_i | input | REL_W (30) | Release countdown reload value |
| idle_to_en_i | input | 1 | Enables the idle-bus timeout event |
| tgt_idle_i | input | 1 | Local target is idle |
| scl_i | input | 1 | Sampled clock line |
| sda_i | input | 1 | Sampled data line |
| start_o | output | 1 | Qualified start, one cycle |
| stop_o | output | 1 | Qualified stop, one cycle |
| bus_free_o | output | 1 | Bus free (always 1 outside multi-controller mode) |
| bus_busy_o | output | 1 | 0 only while in the busy-after-stop state |
| active_to_o | output | 1 | Clock-held-low timeout pulse |
| inactive_to_o | output | 1 | Idle-bus timeout pulse while target engaged |

## Verification
`start_o` and `stop_o` come from registered pending state and a registered window counter, combined with the current samples. So a condition sampled in cycle k is reported in cycle k + 1 + `hold_cycles_i`. The tracker flags (`bus_free_o`, `bus_busy_o`) change one cycle after the line values that cause them. The timeout pulses appear in the same cycle that the registered countdown reads 1. The bench drives the lines just after each falling edge and samples every output one time unit before the next rising edge. Each expected value therefore belongs to exactly one cycle, and the table entries are laid out with those latencies counted.

// File: rtl/bsw_pkg.sv
`timescale 1ns/1ps
package bsw_pkg;
  localparam int unsigned QUAL_W_DEF = 14;
  localparam int unsigned REL_W_DEF  = 30;

  typedef enum logic [1:0] {
    ST_FREE = 2'd0,
    ST_LOW  = 2'd1,
    ST_HIGH = 2'd2,
    ST_POST = 2'd3
  } bus_st_e;
endpackage

// File: rtl/bsw_cond_flag.sv
`timescale 1ns/1ps
module bsw_cond_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic scl_i,
  input  logic set_i,
  input  logic kill_i,
  input  logic met_i,
  output logic pend_o,
  output logic conf_o
);
  assign conf_o = en_i && pend_o && met_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_o <= 1'b0;
    end else if (set_i) begin
      pend_o <= 1'b1;
    end else if (!en_i || !scl_i || conf_o || kill_i) begin
      pend_o <= 1'b0;
    end
  end

  // R2/R3: a confirmation is followed by a cycle without one
  a_r2_conf_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conf_o |=> !conf_o);
endmodule

// File: rtl/bsw_cond_qual.sv
`timescale 1ns/1ps
module bsw_cond_qual #(
  parameter int unsigned QW = 14
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic [QW-1:0] hold_i,
  output logic          start_o,
  output logic          stop_o,
  output logic          line_idle_o
);
  localparam int unsigned NKIND = 2;

  logic          scl_q, sda_q;
  logic [QW-1:0] qcnt_q;
  logic [NKIND-1:0] cand, pend, conf;
  logic          met;

  function automatic logic [QW-1:0] qual_next(input logic [QW-1:0] cnt,
                                              input logic clr, input logic run);
    if (clr) return '0;
    if (run && (cnt != {QW{1'b1}})) return cnt + QW'(1);
    return cnt;
  endfunction

  function automatic logic hold_met(input logic [QW-1:0] cnt, input logic [QW-1:0] hold);
    return cnt >= hold;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  // index 0: start (data falls), index 1: stop (data rises)
  assign cand[0] = en_i && scl_q && scl_i && sda_q && !sda_i;
  assign cand[1] = en_i && scl_q && scl_i && !sda_q && sda_i;
  assign met     = hold_met(qcnt_q, hold_i);

  for (genvar k = 0; k < NKIND; k++) begin : g_kind
    bsw_cond_flag u_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (en_i),
      .scl_i  (scl_i),
      .set_i  (cand[k]),
      .kill_i (cand[NKIND-1-k]),
      .met_i  (met),
      .pend_o (pend[k]),
      .conf_o (conf[k])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) qcnt_q <= '0;
    else         qcnt_q <= qual_next(qcnt_q, |cand, |pend);
  end

  assign start_o     = conf[0];
  assign stop_o      = conf[1];
  assign line_idle_o = scl_i && (sda_i == sda_q);

  // R4: the two qualified events never coincide
  a_r4_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(start_o && stop_o));
  // R4: at most one condition is pending at a time
  a_r4_one_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(pend) <= 1);
endmodule

// File: rtl/bsw_release_cnt.sv
`timescale 1ns/1ps
module bsw_release_cnt #(
  parameter int unsigned RW = 30
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          dec_i,
  input  logic [RW-1:0] reload_i,
  output logic          at_one_o
);
  logic [RW-1:0] cnt_q;

  function automatic logic [RW-1:0] count_next(input logic [RW-1:0] cnt,
                                               input logic ld, input logic dn,
                                               input logic [RW-1:0] val);
    if (ld) return val;
    if (dn && (cnt != '0)) return cnt - RW'(1);
    return cnt;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= count_next(cnt_q, load_i, dec_i, reload_i);
  end

  assign at_one_o = (cnt_q == RW'(1));

  // R6: the countdown rests at zero and never wraps
  a_r6_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0 && !load_i) |=> (cnt_q == '0));
  // R6: at one, a decrement lands on zero
  a_r6_one_to_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (at_one_o && dec_i && !load_i) |=> (cnt_q == '0));
endmodule

// File: rtl/bsw_tracker.sv
`timescale 1ns/1ps
module bsw_tracker import bsw_pkg::*; (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic mc_i,
  input  logic scl_i,
  input  logic sda_i,
  input  logic line_idle_i,
  input  logic stop_conf_i,
  input  logic rel_at_one_i,
  input  logic idle_to_en_i,
  input  logic tgt_idle_i,
  output logic rel_load_o,
  output logic rel_dec_o,
  output logic bus_free_o,
  output logic bus_busy_o,
  output logic active_to_o,
  output logic inactive_to_o
);
  bus_st_e st_q, st_d;
  logic    en_q, en_rise, act_q, act_d, inact_det, any_low;

  assign en_rise = en_i && !en_q;
  assign any_low = !scl_i || !sda_i;

  always_comb begin
    st_d = st_q;
    if (!en_i) begin
      st_d = ST_FREE;
    end else if (en_rise) begin
      st_d = mc_i ? ST_HIGH : ST_FREE;
    end else begin
      case (st_q)
        ST_FREE: if (any_low) st_d = ST_LOW;
        ST_LOW: begin
          if (stop_conf_i)  st_d = ST_POST;
          else if (scl_i)   st_d = ST_HIGH;
        end
        ST_HIGH: begin
          if (stop_conf_i)        st_d = ST_POST;
          else if (!line_idle_i)  st_d = ST_LOW;
          else if (rel_at_one_i)  st_d = ST_FREE;
        end
        ST_POST: begin
          if (any_low)            st_d = ST_LOW;
          else if (rel_at_one_i)  st_d = ST_FREE;
        end
        default: st_d = ST_FREE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_FREE;
      en_q  <= 1'b0;
      act_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      en_q  <= en_i;
      act_q <= act_d;
    end
  end

  assign rel_load_o = en_rise || (en_i && (st_d != st_q));
  assign rel_dec_o  = en_i && !en_rise &&
                      (((st_q == ST_HIGH) && line_idle_i) ||
                       ((st_q == ST_POST) && scl_i && sda_i) ||
                       ((st_q == ST_LOW) && !scl_i));

  assign act_d         = en_i && !en_rise && (st_q == ST_LOW) && !scl_i && rel_at_one_i;
  assign active_to_o   = act_d && !act_q;
  assign inact_det     = en_i && !en_rise && (st_q == ST_HIGH) && line_idle_i &&
                         rel_at_one_i && idle_to_en_i;
  assign inactive_to_o = inact_det && !tgt_idle_i;

  assign bus_free_o = mc_i ? (st_q == ST_FREE) : 1'b1;
  assign bus_busy_o = (st_q != ST_POST);

  // R1: disabling forces the free state
  a_r1_off_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (st_q == ST_FREE));
  // R8: multi-controller enable starts busy-high
  a_r8_mc_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_rise && mc_i) |=> (st_q == ST_HIGH));
  // R7: a confirmed stop from a busy clock state drops the busy flag
  a_r7_stop_post: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !en_rise && stop_conf_i && (st_q == ST_LOW || st_q == ST_HIGH))
      |=> !bus_busy_o);
  // R10: the stuck-low event lasts one cycle
  a_r10_act_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_to_o |=> !active_to_o);
endmodule

// File: rtl/bus_state_watch.sv
`timescale 1ns/1ps
module bus_state_watch import bsw_pkg::*; #(
  parameter int unsigned QUAL_W = QUAL_W_DEF,
  parameter int unsigned REL_W  = REL_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctl_en_i,
  input  logic              tgt_en_i,
  input  logic              mc_en_i,
  input  logic [QUAL_W-1:0] hold_cycles_i,
  input  logic [REL_W-1:0]  release_cycles_i,
  input  logic              idle_to_en_i,
  input  logic              tgt_idle_i,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              start_o,
  output logic              stop_o,
  output logic              bus_free_o,
  output logic              bus_busy_o,
  output logic              active_to_o,
  output logic              inactive_to_o
);
  logic watch_en, line_idle, rel_load, rel_dec, rel_at_one;

  assign watch_en = ctl_en_i | tgt_en_i | mc_en_i;

  bsw_cond_qual #(.QW(QUAL_W)) u_qual (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (watch_en),
    .scl_i       (scl_i),
    .sda_i       (sda_i),
    .hold_i      (hold_cycles_i),
    .start_o     (start_o),
    .stop_o      (stop_o),
    .line_idle_o (line_idle)
  );

  bsw_release_cnt #(.RW(REL_W)) u_rel (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (rel_load),
    .dec_i    (rel_dec),
    .reload_i (release_cycles_i),
    .at_one_o (rel_at_one)
  );

  bsw_tracker u_trk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .en_i          (watch_en),
    .mc_i          (mc_en_i),
    .scl_i         (scl_i),
    .sda_i         (sda_i),
    .line_idle_i   (line_idle),
    .stop_conf_i   (stop_o),
    .rel_at_one_i  (rel_at_one),
    .idle_to_en_i  (idle_to_en_i),
    .tgt_idle_i    (tgt_idle_i),
    .rel_load_o    (rel_load),
    .rel_dec_o     (rel_dec),
    .bus_free_o    (bus_free_o),
    .bus_busy_o    (bus_busy_o),
    .active_to_o   (active_to_o),
    .inactive_to_o (inactive_to_o)
  );

  // R1: nothing is qualified while the monitor is off
  a_r1_off_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !watch_en |-> (!start_o && !stop_o));
endmodule

// File: tb/bus_state_watch_test.sv
`timescale 1ns/1ps
module bus_state_watch_test;
  localparam int CLK_P = 10;
  localparam int NVEC  = 22;
  // bits: [7] scl [6] sda [5] start [4] stop [3] free [2] busy [1] active_to [0] inactive_to
  localparam logic [7:0] VEC [NVEC] = '{
    8'b11001100, 8'b11000100, 8'b11000100, 8'b11000101, 8'b11001100, 8'b10001100,
    8'b10000100, 8'b10000100, 8'b10100100, 8'b00000100, 8'b00000100, 8'b00000100,
    8'b00000110, 8'b10000100, 8'b11000100, 8'b11000100, 8'b11000100, 8'b11010100,
    8'b11000000, 8'b11000000, 8'b11000000, 8'b11001100
  };

  logic clk = 1'b0, rst_ni = 1'b0;
  logic ctl_en, tgt_en, mc_en, idle_to_en, tgt_idle, scl, sda;
  logic [13:0] hold;
  logic [29:0] rel;
  logic start_w, stop_w, free_w, busy_w, act_w, inact_w;
  logic s_start, s_stop, s_free, s_busy, s_act, s_inact;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  bus_state_watch uut (
    .clk_i(clk), .rst_ni(rst_ni), .ctl_en_i(ctl_en), .tgt_en_i(tgt_en), .mc_en_i(mc_en),
    .hold_cycles_i(hold), .release_cycles_i(rel), .idle_to_en_i(idle_to_en),
    .tgt_idle_i(tgt_idle), .scl_i(scl), .sda_i(sda), .start_o(start_w), .stop_o(stop_w),
    .bus_free_o(free_w), .bus_busy_o(busy_w), .active_to_o(act_w), .inactive_to_o(inact_w)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // drive at a falling edge, sample just before the next rising edge
  task automatic cyc(input logic c, input logic d);
    scl = c; sda = d;
    #(CLK_P/2 - 1);
    s_start = start_w; s_stop = stop_w; s_free = free_w;
    s_busy = busy_w; s_act = act_w; s_inact = inact_w;
    @(negedge clk);
  endtask

  task automatic restart(input logic c_en, input logic t_en, input logic m_en,
                         input logic [13:0] h, input logic [29:0] r,
                         input logic ito, input logic tid);
    @(negedge clk);
    rst_ni = 1'b0;
    ctl_en = c_en; tgt_en = t_en; mc_en = m_en; hold = h; rel = r;
    idle_to_en = ito; tgt_idle = tid; scl = 1'b1; sda = 1'b1;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    int cnt_s, cnt_p, bad;
    ctl_en = 0; tgt_en = 0; mc_en = 1; hold = 14'd2; rel = 30'd3;
    idle_to_en = 1; tgt_idle = 0; scl = 1; sda = 1;

    // R12: reset state
    repeat (2) @(negedge clk);
    #(CLK_P/2 - 1);
    check("R12 reset outputs", {2'b00, start_w, stop_w, free_w, busy_w, act_w, inact_w},
          8'b00001100);

    // table: multi-controller, hold 2, release 3 (R2 R3 R5 R6 R7 R8 R10 R11)
    restart(0, 0, 1, 14'd2, 30'd3, 1, 0);
    for (int i = 0; i < NVEC; i++) begin
      cyc(VEC[i][7], VEC[i][6]);
      check($sformatf("R2/R3/R5/R6/R7/R10/R11 vec %0d", i),
            {VEC[i][7:6], s_start, s_stop, s_free, s_busy, s_act, s_inact}, VEC[i]);
    end

    // R2: zero hold reports on the cycle after the candidate
    restart(1, 0, 1, 14'd0, 30'd100, 0, 0);
    cyc(1, 1); cyc(1, 0);
    check("R2 hold0 candidate cycle", {7'd0, s_start}, 8'd0);
    cyc(1, 0);
    check("R2 hold0 next cycle", {7'd0, s_start}, 8'd1);
    cyc(1, 0);
    check("R2 hold0 single pulse", {7'd0, s_start}, 8'd0);

    // R4: SCL low aborts a pending start
    restart(1, 0, 0, 14'd5, 30'd0, 0, 0);
    cnt_s = 0;
    cyc(1, 1); cyc(1, 0); cnt_s += s_start; cyc(1, 0); cnt_s += s_start;
    for (int i = 0; i < 3; i++) begin cyc(0, 0); cnt_s += s_start; end
    for (int i = 0; i < 8; i++) begin cyc(1, 0); cnt_s += s_start; end
    check("R4 aborted start count", 8'(cnt_s), 8'd0);

    // R4 R3: stop candidate replaces a pending start, stop due 4 cycles later
    restart(0, 1, 0, 14'd3, 30'd0, 0, 0);
    cnt_s = 0; cnt_p = 0; bad = 0;
    cyc(1, 1); cyc(1, 0); cnt_s += s_start;
    for (int i = 2; i < 9; i++) begin
      cyc(1, 1);
      cnt_s += s_start; cnt_p += s_stop;
      if (s_stop !== (i == 6)) bad++;
    end
    check("R4 start cancelled by stop", 8'(cnt_s), 8'd0);
    check("R3 stop at cycle 6 only", {8'(cnt_p)}, 8'd1);
    check("R3 stop timing", 8'(bad), 8'd0);

    // R11: target idle masks the idle-bus event; bus still freed
    restart(0, 0, 1, 14'd2, 30'd2, 1, 1);
    cyc(1, 1); cyc(1, 1); cyc(1, 1);
    check("R11 masked by target idle", {7'd0, s_inact}, 8'd0);
    cyc(1, 1);
    check("R6 freed after release count", {7'd0, s_free}, 8'd1);
    restart(0, 0, 1, 14'd2, 30'd2, 0, 0);
    cyc(1, 1); cyc(1, 1); cyc(1, 1);
    check("R11 timeout enable off", {7'd0, s_inact}, 8'd0);

    // R1 R9: all enables off, line activity ignored
    restart(0, 0, 0, 14'd0, 30'd1, 1, 0);
    bad = 0;
    for (int i = 0; i < 10; i++) begin
      cyc((i % 4) != 3, (i % 2) == 0);
      if (s_start || s_stop || !s_free || !s_busy || s_act || s_inact) bad++;
    end
    check("R1 disabled outputs idle", 8'(bad), 8'd0);

    // R6: zero release value never frees the bus
    restart(0, 0, 1, 14'd2, 30'd0, 1, 0);
    for (int i = 0; i < 12; i++) cyc(1, 1);
    check("R6 release 0 stays busy", {7'd0, s_free}, 8'd0);

    // R8 R9 R7: single-controller enable starts free; stop leads to post-stop
    restart(1, 0, 0, 14'd1, 30'd2, 1, 0);
    bad = 0;
    for (int i = 0; i < 4; i++) begin cyc(1, 1); if (s_inact) bad++; end
    check("R8 single mode enters free", 8'(bad), 8'd0);
    cyc(0, 0); cyc(1, 0); cyc(1, 1); cyc(1, 1);
    check("R3 no early stop", {7'd0, s_stop}, 8'd0);
    cyc(1, 1);
    check("R3 single mode stop", {7'd0, s_stop}, 8'd1);
    cyc(1, 1);
    check("R7 post-stop busy low", {7'd0, s_busy}, 8'd0);
    check("R9 free in single mode", {7'd0, s_free}, 8'd1);

    finish_run();
  end
endmodule